// File: doc/BRIEF.md
# Hamming Parity Code Accumulator

This block computes a single-error-correcting Hamming code beside a NAND flash data path. While it is in its accumulate mode it observes every data byte that moves on the flash bus. For each chunk of `CHUNK_BYTES` bytes (256 by default) it builds three code bytes from line parities and column parities. It stores one code per chunk for `NUM_CHUNKS` chunks, two by default, which covers a 512-byte page. The block only generates the code. Software compares the stored code with the code kept in the spare area and corrects any error.

The host controls the block through a 2-bit mode field inside its control write. A computation starts with the sequence clear, off, accumulate. The page data then flows past the block. The host then selects read-out mode and fetches the code bytes one at a time through the shared data read path, and returns the mode to off when it is done.

Top module: `hecc_accum`

## Requirements
- R1: The mode is taken from bits 6:5 of `ctl_wdata` on a cycle with `ctl_we` high, and all other bits are ignored. The encodings are 2'b11 clear, 2'b10 read-out, 2'b01 accumulate and 2'b00 off. The mode after reset is off.
- R2: Clear mode empties the byte counter and the accumulators of every chunk. A read-out with no data accumulated returns 8'hFF for every code byte.
- R3: Line parities. Take byte index i within its chunk and address bit k. The odd line parity of k is the XOR of all bits of the bytes with bit k of i set. The even line parity of k is the XOR over the bytes with bit k of i clear. In the default configuration, code byte A is {odd7, even7, odd6, even6, odd5, even5, odd4, even4} from MSB to LSB, and code byte B is the same pattern for k = 3 down to 0.
- R4: Column parities form code byte C = {P4o, P4e, P2o, P2e, P1o, P1e, 1, 1} from MSB to LSB. P1o is the XOR of the odd bit positions over the chunk and P1e the XOR of the even ones. P2o covers bits {2,3,6,7} and P2e bits {0,1,4,5}. P4o covers bits 7:4 and P4e bits 3:0. Every code bit is stored inverted.
- R5: Accumulated bytes go to chunk 0 for the first `CHUNK_BYTES` bytes and to chunk 1 for the next `CHUNK_BYTES` bytes. Bytes beyond `NUM_CHUNKS*CHUNK_BYTES` are ignored.
- R6: Bytes presented with `xfer_valid` while the mode is off or read-out leave the stored codes and the byte count unchanged. Accumulation resumes where it stopped when the mode returns to accumulate.
- R7: In read-out mode `rd_data` presents the current code byte. Each `rd_req` cycle advances to the next byte in the order chunk 0 A, B, C, then chunk 1 A, B, C. After the last byte it wraps to the first.
- R8: Every entry into read-out mode from another mode restarts the stream at chunk 0 byte A.
- R9: Outside read-out mode `rd_data` is 8'h00, and `rd_req` has no visible effect.
- R10: A chunk of 256 bytes of 8'hFF yields 8'hFF for all three of its code bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write data; the mode is in bits 6:5 |
| xfer_valid | input | 1 | A data byte moves on the flash bus this cycle |
| xfer_data | input | 8 | The byte on the flash bus |
| rd_req | input | 1 | Data read strobe that consumes one code byte |
| rd_data | output | 8 | Current code byte in read-out mode, zero otherwise |

## Verification
The assertions assume that the host never presents a byte in the same cycle as a mode write. A byte arriving together with the write that leaves accumulate would still be counted under the old mode. They also assume that read strobes come only after the mode write has taken effect. The bench drives every mode change, byte and read strobe in its own cycle on the falling edge, so these assumptions always hold. The stored-code stability checks in off and read-out modes therefore see only legal traffic, even though the bench deliberately streams ignored bytes in those modes.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

   typedef enum logic [1:0] {
      HM_OFF   = 2'b00,
      HM_ACC   = 2'b01,
      HM_READ  = 2'b10,
      HM_CLEAR = 2'b11
   } hecc_mode_e;

   localparam int unsigned CODE_BYTES = 3;
   localparam int unsigned LINE_MAX   = 8;
   localparam int unsigned MODE_W     = 2;

   // raw per-chunk accumulator: column xor, odd and even line parities
   typedef struct packed {
      logic [7:0]          col;
      logic [LINE_MAX-1:0] lodd;
      logic [LINE_MAX-1:0] leven;
   } hecc_acc_t;

   localparam int unsigned ACC_W = $bits(hecc_acc_t);

   // form the three inverted code bytes {A, B, C} from a raw accumulator
   function automatic logic [23:0] hecc_pack(input hecc_acc_t a);
      logic [15:0] lp;
      logic [5:0]  cp;
      for (int k = 0; k < LINE_MAX; k++) begin
         lp[2*k]   = a.leven[k];
         lp[2*k+1] = a.lodd[k];
      end
      cp = {^(a.col & 8'hF0), ^(a.col & 8'h0F),
            ^(a.col & 8'hCC), ^(a.col & 8'h33),
            ^(a.col & 8'hAA), ^(a.col & 8'h55)};
      return ~{lp[15:8], lp[7:0], cp, 2'b00};
   endfunction

endpackage

// File: rtl/hecc_mode_ctrl.sv
module hecc_mode_ctrl
   import hecc_pkg::*;
#(
   parameter int unsigned CTL_W    = 8,
   parameter int unsigned MODE_LSB = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output hecc_mode_e       mode_q,
   output logic             clr,
   output logic             acc_on,
   output logic             rd_enter
);

   generate
      if (MODE_LSB + MODE_W > CTL_W) begin : g_bad_field
         $error("hecc_mode_ctrl: mode field exceeds control width");
      end
   endgenerate

   hecc_mode_e wmode;

   assign wmode = hecc_mode_e'(ctl_wdata[MODE_LSB +: MODE_W]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= HM_OFF;
      end else if (ctl_we) begin
         mode_q <= wmode;
      end
   end

   assign clr      = (ctl_we && (wmode == HM_CLEAR)) || (mode_q == HM_CLEAR);
   assign acc_on   = (mode_q == HM_ACC);
   assign rd_enter = ctl_we && (wmode == HM_READ) && (mode_q != HM_READ);

endmodule

// File: rtl/hecc_byte_cnt.sv
module hecc_byte_cnt #(
   parameter  int unsigned CHUNK_BYTES = 256,
   parameter  int unsigned NUM_CHUNKS  = 2,
   localparam int unsigned TOTAL       = CHUNK_BYTES * NUM_CHUNKS,
   localparam int unsigned IDX_W       = $clog2(CHUNK_BYTES),
   localparam int unsigned CNT_W       = $clog2(TOTAL + 1),
   localparam int unsigned CSEL_W      = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              take,
   output logic [CSEL_W-1:0] chunk_sel,
   output logic [IDX_W-1:0]  byte_idx
);

   logic             full;
   logic [CNT_W-1:0] shifted;

   assign full      = (cnt_q == CNT_W'(TOTAL));
   assign take      = step && !full;
   assign shifted   = cnt_q >> IDX_W;
   assign chunk_sel = shifted[CSEL_W-1:0];
   assign byte_idx  = cnt_q[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (take) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/hecc_chunk_bank.sv
module hecc_chunk_bank
   import hecc_pkg::*;
#(
   parameter  int unsigned CHUNK_BYTES = 256,
   parameter  int unsigned NUM_CHUNKS  = 2,
   localparam int unsigned IDX_W       = $clog2(CHUNK_BYTES),
   localparam int unsigned CSEL_W      = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         take,
   input  logic [CSEL_W-1:0]            chunk_sel,
   input  logic [IDX_W-1:0]             byte_idx,
   input  logic [7:0]                   data,
   output hecc_acc_t [NUM_CHUNKS-1:0]   acc_q
);

   localparam logic [LINE_MAX-1:0] LMASK = LINE_MAX'((1 << IDX_W) - 1);

   logic                bpar;
   logic [LINE_MAX-1:0] idx8;
   logic [LINE_MAX-1:0] odd_m;
   logic [LINE_MAX-1:0] even_m;
   hecc_acc_t           delta;

   assign bpar   = ^data;
   assign idx8   = LINE_MAX'(byte_idx);
   assign odd_m  = {LINE_MAX{bpar}} & idx8;
   assign even_m = {LINE_MAX{bpar}} & ~idx8 & LMASK;
   assign delta  = '{col: data, lodd: odd_m, leven: even_m};

   generate
      for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
         hecc_acc_t r;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               r <= '0;
            end else if (clr) begin
               r <= '0;
            end else if (take && (chunk_sel == CSEL_W'(g))) begin
               r <= r ^ delta;
            end
         end
         assign acc_q[g] = r;
      end
   endgenerate

endmodule

// File: rtl/hecc_readout.sv
module hecc_readout
   import hecc_pkg::*;
#(
   parameter  int unsigned NUM_CHUNKS = 2,
   localparam int unsigned NB         = NUM_CHUNKS * CODE_BYTES,
   localparam int unsigned PTR_W      = $clog2(NB)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  hecc_mode_e                 mode_q,
   input  logic                       rd_enter,
   input  logic                       rd_req,
   input  hecc_acc_t [NUM_CHUNKS-1:0] acc_bus,
   output logic [7:0]                 rd_data,
   output logic [PTR_W-1:0]           ptr_q
);

   logic [NB-1:0][7:0] stream;

   generate
      for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_code
         logic [23:0] code;
         assign code = hecc_pack(acc_bus[g]);
         for (genvar s = 0; s < CODE_BYTES; s++) begin : g_byte
            assign stream[g*CODE_BYTES + s] = code[23 - 8*s -: 8];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (rd_enter) begin
         ptr_q <= '0;
      end else if ((mode_q == HM_READ) && rd_req) begin
         ptr_q <= (ptr_q == PTR_W'(NB - 1)) ? '0 : ptr_q + PTR_W'(1);
      end
   end

   assign rd_data = (mode_q == HM_READ) ? stream[ptr_q] : 8'h00;

endmodule

// File: rtl/hecc_accum.sv
module hecc_accum
   import hecc_pkg::*;
#(
   parameter int unsigned CHUNK_BYTES = 256,
   parameter int unsigned NUM_CHUNKS  = 2,
   parameter int unsigned MODE_LSB    = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic [7:0] ctl_wdata,
   input  logic       xfer_valid,
   input  logic [7:0] xfer_data,
   input  logic       rd_req,
   output logic [7:0] rd_data
);

   localparam int unsigned TOTAL  = CHUNK_BYTES * NUM_CHUNKS;
   localparam int unsigned IDX_W  = $clog2(CHUNK_BYTES);
   localparam int unsigned CNT_W  = $clog2(TOTAL + 1);
   localparam int unsigned CSEL_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;
   localparam int unsigned NB     = NUM_CHUNKS * CODE_BYTES;
   localparam int unsigned PTR_W  = $clog2(NB);

   generate
      if ((CHUNK_BYTES < 2) || (CHUNK_BYTES > 256) ||
          ((CHUNK_BYTES & (CHUNK_BYTES - 1)) != 0)) begin : g_bad_chunk
         $error("hecc_accum: CHUNK_BYTES must be a power of two in 2..256");
      end
      if (NUM_CHUNKS < 1) begin : g_bad_count
         $error("hecc_accum: NUM_CHUNKS must be at least one");
      end
   endgenerate

   hecc_mode_e                 mode_q;
   logic                       clr;
   logic                       acc_on;
   logic                       rd_enter;
   logic [CNT_W-1:0]           cnt_q;
   logic                       take;
   logic [CSEL_W-1:0]          chunk_sel;
   logic [IDX_W-1:0]           byte_idx;
   hecc_acc_t [NUM_CHUNKS-1:0] acc_bus;
   logic [PTR_W-1:0]           ptr_q;

   hecc_mode_ctrl #(
      .CTL_W    (8),
      .MODE_LSB (MODE_LSB)
   ) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctl_wdata (ctl_wdata),
      .mode_q    (mode_q),
      .clr       (clr),
      .acc_on    (acc_on),
      .rd_enter  (rd_enter)
   );

   hecc_byte_cnt #(
      .CHUNK_BYTES (CHUNK_BYTES),
      .NUM_CHUNKS  (NUM_CHUNKS)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .step      (acc_on && xfer_valid),
      .cnt_q     (cnt_q),
      .take      (take),
      .chunk_sel (chunk_sel),
      .byte_idx  (byte_idx)
   );

   hecc_chunk_bank #(
      .CHUNK_BYTES (CHUNK_BYTES),
      .NUM_CHUNKS  (NUM_CHUNKS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .take      (take),
      .chunk_sel (chunk_sel),
      .byte_idx  (byte_idx),
      .data      (xfer_data),
      .acc_q     (acc_bus)
   );

   hecc_readout #(
      .NUM_CHUNKS (NUM_CHUNKS)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_q   (mode_q),
      .rd_enter (rd_enter),
      .rd_req   (rd_req),
      .acc_bus  (acc_bus),
      .rd_data  (rd_data),
      .ptr_q    (ptr_q)
   );

endmodule

// File: rtl/hecc_accum_chk.sv
module hecc_accum_chk #(
   parameter  int unsigned CHUNK_BYTES = 256,
   parameter  int unsigned NUM_CHUNKS  = 2,
   parameter  int unsigned MODE_LSB    = 5,
   localparam int unsigned TOTAL       = CHUNK_BYTES * NUM_CHUNKS,
   localparam int unsigned CNT_W       = $clog2(TOTAL + 1),
   localparam int unsigned NB          = NUM_CHUNKS * 3,
   localparam int unsigned PTR_W       = $clog2(NB),
   localparam int unsigned AW          = NUM_CHUNKS * 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_we,
   input logic [7:0]       ctl_wdata,
   input logic             xfer_valid,
   input logic             rd_req,
   input logic [7:0]       rd_data,
   input logic [1:0]       mode_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic [PTR_W-1:0] ptr_q,
   input logic [AW-1:0]    acc_flat
);

   logic [1:0] wm;
   assign wm = ctl_wdata[MODE_LSB +: 2];

   assert_mode_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (mode_q == $past(wm)));

   assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && (wm == 2'b11)) |=> ((cnt_q == '0) && (acc_flat == '0)));

   assert_no_xfer_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_valid && !ctl_we && (mode_q != 2'b11)) |=> $stable(acc_flat));

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(TOTAL));

   assert_off_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 2'b00) && !ctl_we) |=> ($stable(acc_flat) && $stable(cnt_q)));

   assert_read_holds_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 2'b10) && !ctl_we) |=> $stable(acc_flat));

   assert_read_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 2'b10) && !ctl_we && !rd_req) |=> $stable(rd_data));

   assert_ptr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q < PTR_W'(NB));

   assert_entry_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && (wm == 2'b10) && (mode_q != 2'b10)) |=> (ptr_q == '0));

   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && (wm != 2'b10)) |=> (rd_data == 8'h00));

endmodule

bind hecc_accum hecc_accum_chk #(
   .CHUNK_BYTES (CHUNK_BYTES),
   .NUM_CHUNKS  (NUM_CHUNKS),
   .MODE_LSB    (MODE_LSB)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_we     (ctl_we),
   .ctl_wdata  (ctl_wdata),
   .xfer_valid (xfer_valid),
   .rd_req     (rd_req),
   .rd_data    (rd_data),
   .mode_q     (mode_q),
   .cnt_q      (cnt_q),
   .ptr_q      (ptr_q),
   .acc_flat   (acc_bus)
);

// File: tb/tb_hecc_accum.sv
module tb_hecc_accum;

   localparam int CB  = 256;
   localparam int NC  = 2;
   localparam int TOT = CB * NC;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ctl_we;
   logic [7:0] ctl_wdata;
   logic       xfer_valid;
   logic [7:0] xfer_data;
   logic       rd_req;
   logic [7:0] rd_data;

   int         n_run  = 0;
   int         n_fail = 0;
   int         cyc    = 0;
   logic [7:0] mem [TOT];
   int         nfill  = 0;

   always #5 clk = ~clk;

   hecc_accum #(.CHUNK_BYTES(CB), .NUM_CHUNKS(NC)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we     (ctl_we),
      .ctl_wdata  (ctl_wdata),
      .xfer_valid (xfer_valid),
      .xfer_data  (xfer_data),
      .rd_req     (rd_req),
      .rd_data    (rd_data)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog (all requirements): got %0d cycles expected completion", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   // mode in bits 6:5, junk in the other bits (R1)
   task automatic wr_mode(input logic [1:0] m);
      ctl_wdata      = 8'h9F;
      ctl_wdata[6:5] = m;
      ctl_we         = 1'b1;
      @(negedge clk);
      ctl_we         = 1'b0;
   endtask

   task automatic push(input logic [7:0] b, input bit rec);
      xfer_valid = 1'b1;
      xfer_data  = b;
      @(negedge clk);
      xfer_valid = 1'b0;
      if (rec) begin
         if (nfill < TOT) mem[nfill] = b;
         nfill++;
      end
   endtask

   task automatic start();
      wr_mode(2'b11);
      wr_mode(2'b00);
      wr_mode(2'b01);
      nfill = 0;
   endtask

   function automatic logic [7:0] exp_code(input int j);
      int         c  = j / 3;
      int         s  = j % 3;
      logic [7:0] le = '0;
      logic [7:0] lo = '0;
      logic       p1e = 0, p1o = 0, p2e = 0, p2o = 0, p4e = 0, p4o = 0;
      for (int i = 0; i < CB; i++) begin
         int g = c * CB + i;
         if (g < nfill && g < TOT) begin
            for (int b = 0; b < 8; b++) begin
               if (mem[g][b]) begin
                  for (int k = 0; k < 8; k++) begin
                     if (((i >> k) & 1) != 0) lo[k] = ~lo[k];
                     else                     le[k] = ~le[k];
                  end
                  if ((b & 1) != 0) p1o = ~p1o; else p1e = ~p1e;
                  if ((b & 2) != 0) p2o = ~p2o; else p2e = ~p2e;
                  if ((b & 4) != 0) p4o = ~p4o; else p4e = ~p4e;
               end
            end
         end
      end
      case (s)
         0:       return ~{lo[7], le[7], lo[6], le[6], lo[5], le[5], lo[4], le[4]};
         1:       return ~{lo[3], le[3], lo[2], le[2], lo[1], le[1], lo[0], le[0]};
         default: return ~{p4o, p4e, p2o, p2e, p1o, p1e, 2'b00};
      endcase
   endfunction

   task automatic read_chk(input logic [7:0] exp, input string tag);
      check8(tag, rd_data, exp);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic read_all(input string tag);
      for (int j = 0; j < NC * 3; j++) read_chk(exp_code(j), tag);
   endtask

   initial begin
      rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
      xfer_valid = 1'b0; xfer_data = '0; rd_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state is off, data path reads zero
      check8("R9 reset idle", rd_data, 8'h00);

      // R2: nothing accumulated gives all-ones code
      nfill = 0;
      wr_mode(2'b10);
      read_all("R2 empty after reset");
      wr_mode(2'b00);
      check8("R9 off after read-out", rd_data, 8'h00);

      // R10: erased page
      start();
      for (int i = 0; i < TOT; i++) push(8'hFF, 1);
      wr_mode(2'b10);
      read_all("R10 erased page");
      wr_mode(2'b00);

      // R1 R3 R4: pseudo-random page
      start();
      begin
         logic [15:0] lfsr = 16'hACE1;
         for (int i = 0; i < TOT; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            push(lfsr[7:0], 1);
         end
      end
      wr_mode(2'b10);
      read_all("R1 R3 R4 random page");
      wr_mode(2'b00);

      // R3 R4: structured page
      start();
      for (int i = 0; i < TOT; i++) push(8'(i ^ (i >> 3)), 1);
      wr_mode(2'b10);
      read_all("R3 R4 structured page");
      wr_mode(2'b00);

      // R2: clear after data wipes it
      wr_mode(2'b11);
      wr_mode(2'b10);
      nfill = 0;
      read_all("R2 clear after data");
      wr_mode(2'b00);

      // R5: partial second chunk
      start();
      for (int i = 0; i < 300; i++) push(8'(i * 7 + 3), 1);
      wr_mode(2'b10);
      read_all("R5 partial chunk1");
      wr_mode(2'b00);

      // R5: bytes beyond capacity ignored
      start();
      for (int i = 0; i < 600; i++) push(8'(i * 13 + 1), 1);
      wr_mode(2'b10);
      read_all("R5 overflow ignored");
      wr_mode(2'b00);

      // R6: off and read-out traffic ignored
      start();
      for (int i = 0; i < 100; i++) push(8'(i + 5), 1);
      wr_mode(2'b00);
      for (int i = 0; i < 50; i++) push(8'hA5, 0);
      wr_mode(2'b01);
      for (int i = 0; i < 200; i++) push(8'(i * 3), 1);
      wr_mode(2'b10);
      for (int i = 0; i < 20; i++) push(8'h3C, 0);
      read_all("R6 off/read-out ignored");

      // R7: wrap after last byte
      read_chk(exp_code(0), "R7 wrap to first");
      read_chk(exp_code(1), "R7 after wrap");
      read_chk(exp_code(2), "R7 after wrap");

      // R8: re-entry restarts stream
      wr_mode(2'b00);
      // R9: read strobes outside read-out do nothing visible
      for (int i = 0; i < 3; i++) begin
         rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
         check8("R9 strobe while off", rd_data, 8'h00);
      end
      wr_mode(2'b10);
      read_chk(exp_code(0), "R8 restart on entry");
      read_chk(exp_code(1), "R8 second after restart");
      wr_mode(2'b00);

      // R3 R4: single-bit sweep over chunk 0
      for (int p = 0; p < CB; p += 17) begin
         for (int b = 0; b < 8; b++) begin
            start();
            for (int i = 0; i < CB; i++) push((i == p) ? 8'(1 << b) : 8'h00, 1);
            wr_mode(2'b10);
            read_all("R3 R4 single-bit sweep");
            wr_mode(2'b00);
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule